// File: doc/BRIEF.md
# Keypad Matrix Scanner with Strap-Selected Code Bank

This block scans a key matrix of seven drive outputs and eight active-low sense inputs and turns one pressed key into a 9-bit code address for a remote-control encoder. While no key is held, the block rests in an idle state. It pulls every drive line low and watches the sense inputs. A low on an enabled sense input raises a combinational wake request, and scanning starts on the next clock. During a scan, one drive line at a time goes low. An external tick advances the scan slot, and the sense inputs are sampled on that tick.

A configuration input picks one of two bank modes. In strap mode, sense line 0 carries no keys. Instead it reads a jumper that ties it to one drive line or to ground, and the jumper position becomes the bank number. The matrix then holds at most 49 keys. In key mode, sense line 0 scans keys like the other lines, and the bank field is zero. The bank then comes from key-based selection downstream. A key is reported only when the same single key appears in two consecutive scans. When that holds, the block gives one valid pulse per scan for as long as the key is held.

Top module: `keypad_bank_scanner`

## Requirements
- R1: While idle, every drive output is low, and `wake` is high exactly when an enabled sense input is low. Sense 0 is not an enabled input in strap mode.
- R2: While scanning, exactly one drive output is low. The scan starts at drive 0, each `tick` moves it to the next drive, and the scan ends after drive 6.
- R3: In strap mode (`strap_mode`=1), sense 0 low in exactly one slot k gives bank k, and sense 0 low in all seven slots gives bank 7. Any other pattern reports no key for that scan.
- R4: In strap mode, sense 0 never counts as a key.
- R5: In key mode (`strap_mode`=0), sense 0 scans keys and the bank field is 0.
- R6: A scan that finds two or more keys reports nothing.
- R7: `key_code` is {bank[8:6], drive index[5:3], sense index[2:0]}.
- R8: `key_valid` is a one-cycle pulse at the end of a scan. It is raised only when that scan and the one before it each found the same single key, with a valid bank.
- R9: A scan that finds no key returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Scan slot advance strobe |
| strap_mode | input | 1 | 1 = bank from strap on sense 0, 0 = key mode |
| sense_n | input | 8 | Matrix sense inputs, active low |
| drive_n | output | 7 | Matrix drive outputs, low = driven |
| wake | output | 1 | Start request while idle |
| key_valid | output | 1 | One-cycle strobe for a debounced key |
| key_code | output | 9 | Bank, drive index and sense index |

## Verification
Errors in the slot counter or the strap accumulator show up in the next `key_code` as a wrong bank or drive field. They appear at the end of the second scan after a press, about 14 ticks later. Errors in the debounce history show up as a pulse after a single scan or as a missing pulse. A stuck scanning flag shows at once: the drive outputs stay non-zero, or `wake` stays high with a key held.

// File: rtl/keypad_bank_scanner.sv
module keypad_bank_scanner #(
  parameter int DRIVES = 7,
  parameter int SENSES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                strap_mode,
  input  logic [SENSES-1:0]   sense_n,
  output logic [DRIVES-1:0]   drive_n,
  output logic                wake,
  output logic                key_valid,
  output logic [8:0]          key_code
);
  localparam int DW = $clog2(DRIVES);
  localparam int SW = $clog2(SENSES);
  localparam int BW = $clog2(DRIVES + 1);
  localparam int CW = BW + DW + SW;
  localparam logic [BW-1:0] GND_BANK = BW'(DRIVES);

  logic          scanning;
  logic [DW-1:0] slot;
  logic [BW-1:0] sn0_cnt, sn0_idx;
  logic [1:0]    kcnt;
  logic [DW-1:0] kdrv;
  logic [SW-1:0] ksns;
  logic [CW-1:0] prev_code;
  logic          prev_ok;

  wire [SENSES-1:0] hit = ~sense_n & {{(SENSES-1){1'b1}}, ~strap_mode};
  wire              last = (slot == DW'(DRIVES-1));

  assign wake    = !scanning && (|hit);
  assign drive_n = scanning ? ~(DRIVES'(1) << slot) : '0;

  logic [1:0]    slot_hits, nk;
  logic [SW-1:0] low_idx;
  always_comb begin
    slot_hits = 2'd0;
    low_idx   = '0;
    for (int i = SENSES-1; i >= 0; i--)
      if (hit[i]) begin
        low_idx = SW'(i);
        if (slot_hits != 2'd2) slot_hits = slot_hits + 2'd1;
      end
    nk = (kcnt + slot_hits > 2'd2 || kcnt == 2'd2) ? 2'd2 : kcnt + slot_hits;
  end

  wire           s0    = strap_mode && !sense_n[0];
  wire [BW-1:0]  n_cnt = sn0_cnt + BW'(s0);
  wire [BW-1:0]  n_idx = s0 ? BW'(slot) : sn0_idx;
  wire           first = (kcnt == 2'd0) && (slot_hits != 2'd0);
  wire [DW-1:0]  n_kdrv = first ? slot : kdrv;
  wire [SW-1:0]  n_ksns = first ? low_idx : ksns;

  logic [BW-1:0] bank;
  logic          bank_ok;
  always_comb begin
    bank = '0; bank_ok = 1'b1;
    if (strap_mode) begin
      if (n_cnt == BW'(DRIVES)) bank = GND_BANK;
      else if (n_cnt == BW'(1)) bank = n_idx;
      else bank_ok = 1'b0;
    end
  end

  wire [CW-1:0] code   = {bank, n_kdrv, n_ksns};
  wire          single = (nk == 2'd1) && bank_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scanning <= 1'b0; slot <= '0; sn0_cnt <= '0; sn0_idx <= '0;
      kcnt <= '0; kdrv <= '0; ksns <= '0;
      prev_code <= '0; prev_ok <= 1'b0; key_valid <= 1'b0; key_code <= '0;
    end else begin
      key_valid <= 1'b0;
      if (!scanning) begin
        if (|hit) begin
          scanning <= 1'b1;
          slot     <= '0;
        end
      end else if (tick) begin
        if (!last) begin
          slot <= slot + DW'(1);
          kcnt <= nk; kdrv <= n_kdrv; ksns <= n_ksns;
          sn0_cnt <= n_cnt; sn0_idx <= n_idx;
        end else begin
          slot <= '0;
          kcnt <= '0; kdrv <= '0; ksns <= '0; sn0_cnt <= '0; sn0_idx <= '0;
          prev_ok   <= single;
          prev_code <= code;
          if (single && prev_ok && code == prev_code) begin
            key_valid <= 1'b1;
            key_code  <= 9'(code);
          end
          if (nk == 2'd0) scanning <= 1'b0;
        end
      end
    end
  end

  // R2
  drive_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scanning |-> $countones(~drive_n) == 1);
  // R1
  idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scanning |-> drive_n == '0);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);
  // R8
  valid_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_valid) |-> $past(scanning) && $past(tick));
  // R1
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> drive_n == '0);
endmodule

// File: tb/sim_keypad_bank_scanner.sv
module sim_keypad_bank_scanner;
  logic clk = 0, rst_n = 0, tick = 0, strap_mode = 0;
  logic [7:0] sense_n;
  logic [6:0] drive_n;
  logic wake, key_valid;
  logic [8:0] key_code;
  logic [6:0][7:0] pressed = '0;
  int strap = 8;
  int n_run = 0, n_fail = 0, vcnt = 0, cyc = 0;
  logic [8:0] vcode = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  keypad_bank_scanner u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .strap_mode(strap_mode),
    .sense_n(sense_n), .drive_n(drive_n), .wake(wake), .key_valid(key_valid), .key_code(key_code));

  always_comb begin
    sense_n = '1;
    for (int d = 0; d < 7; d++)
      for (int s = 0; s < 8; s++)
        if (pressed[d][s] && !drive_n[d]) sense_n[s] = 1'b0;
    if (strap < 7 && !drive_n[strap]) sense_n[0] = 1'b0;
    if (strap == 7) sense_n[0] = 1'b0;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (key_valid) begin vcnt <= vcnt + 1; vcode <= key_code; end
  end

  initial forever begin
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    repeat (2) @(negedge clk);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  // {mode, strap[3:0], drive[2:0], sense[2:0], expect_valid, code[8:0]}
  localparam logic [20:0] VEC [6] = '{
    {1'b1, 4'd3, 3'd2, 3'd5, 1'b1, 9'd213},
    {1'b1, 4'd7, 3'd6, 3'd1, 1'b1, 9'd497},
    {1'b1, 4'd0, 3'd0, 3'd7, 1'b1, 9'd7},
    {1'b0, 4'd8, 3'd4, 3'd0, 1'b1, 9'd32},
    {1'b1, 4'd8, 3'd1, 3'd3, 1'b0, 9'd0},
    {1'b1, 4'd6, 3'd5, 3'd2, 1'b1, 9'd426}
  };

  task automatic release_and_idle();
    pressed = '0;
    repeat (120) @(negedge clk);
    chk(drive_n == 7'h00, "R9 idle drive", drive_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(drive_n == 0 && !wake && !key_valid, "R1 reset state", {wake, key_valid, drive_n}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      strap_mode = VEC[i][20];
      strap = int'(VEC[i][19:16]);
      repeat (2) @(negedge clk);
      vcnt = 0;
      pressed[VEC[i][15:13]][VEC[i][12:10]] = 1'b1;
      repeat (220) @(negedge clk);
      if (VEC[i][9]) begin
        chk(vcnt >= 3, "R8 repeated reports", vcnt, 3);
        chk(vcode == VEC[i][8:0], "R3 R5 R7 code", vcode, VEC[i][8:0]);
      end else
        chk(vcnt == 0, "R3 open strap no report", vcnt, 0);
      release_and_idle();
    end

    // R4: strap grounded, no keys, strap mode: no wake, stays idle
    strap_mode = 1; strap = 7;
    repeat (10) @(negedge clk);
    chk(!wake && drive_n == 0, "R4 sense0 ignored", {wake, drive_n}, 0);

    // R1: key mode wake is immediate
    strap_mode = 0; strap = 8;
    @(negedge clk);
    pressed[3][3] = 1'b1;
    #1 chk(wake == 1, "R1 wake on press", wake, 1);
    @(negedge clk);
    chk(drive_n == 7'b1111110, "R2 first slot drive0", drive_n, 7'b1111110);
    pressed = '0;
    release_and_idle();

    // R8 debounce latency (two scans)
    strap_mode = 1; strap = 4;
    repeat (2) @(negedge clk);
    vcnt = 0;
    begin
      int t0;
      t0 = cyc;
      pressed[2][6] = 1'b1;
      while (vcnt == 0 && cyc - t0 < 400) @(negedge clk);
      chk((cyc - t0) >= 45 && (cyc - t0) <= 72, "R8 two-scan latency", cyc - t0, 56);
      chk(vcode == 9'd278, "R7 strap4 d2 s6", vcode, 278);
    end
    release_and_idle();

    // R6 two keys
    strap_mode = 1; strap = 2;
    vcnt = 0;
    pressed[1][2] = 1'b1; pressed[3][4] = 1'b1;
    repeat (220) @(negedge clk);
    chk(vcnt == 0, "R6 multi-key no report", vcnt, 0);
    chk(drive_n != 0, "R6 still scanning", drive_n, 1);
    release_and_idle();

    // R6 two keys same drive line, key mode
    strap_mode = 0; strap = 8;
    vcnt = 0;
    pressed[5][1] = 1'b1; pressed[5][6] = 1'b1;
    repeat (220) @(negedge clk);
    chk(vcnt == 0, "R6 same-row multi-key", vcnt, 0);
    release_and_idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule